// File: doc/BRIEF.md
# IR Raw Symbol Capture Controller

This block watches the demodulated output of an infrared receiver and measures every symbol that arrives. A symbol opens on a falling edge of the line and consists of a low (pulse) phase followed by a high (space) phase. Both durations are counted in units of ten microseconds. They are packed into one 32-bit word and pushed into a small symbol FIFO. Software drains the FIFO through a register port and learns about new symbols, stream ends and overflows through one level-sensitive interrupt.

A stream ends when the line stays high long enough that low plus high reaches a programmable maximum width. The last symbol is then closed with its space field trimmed to the remaining width, and a timeout is flagged. When the FIFO is full, new words are dropped and an overflow is flagged, but the stored words stay in place until software reads them out. Only raw capture is offered; protocol decoding and carrier removal happen elsewhere.

Register offsets (byte addresses): enable 0x00, config 0x04, busy 0x08, count 0x0C, data 0x10, mask 0x14, status 0x18, clear 0x1C, start 0x20.

Top module: `ir_symbol_capture`

## Requirements
- R1: After reset the config register reads 0x3E800080 (maximum width 16000 in bits [31:16], level 0 in bits [13:8], raw bit 7 set, prescale 0 in bits [6:0]), mask reads 0x00000700, and count, status, busy and irq are all zero.
- R2: Writing 1 to enable bit 0 while disabled makes busy read 1 for BUSY_CYCLES clocks; a write to start is ignored while busy is 1 or enable is 0, and a write to start once busy reads 0 begins capture.
- R3: A symbol word carries the low-phase duration in bits [15:0] and the high-phase duration in bits [31:16]; a phase lasting N clocks reports floor((N-1)/U) units, where U = (prescale+1)*10 clocks.
- R4: A symbol opens only on a falling edge of the synchronized input; a line that stays high while capture runs produces no word.
- R5: When low plus high reaches the maximum width, the symbol is pushed with its high field set to width minus low, status bit 9 (timeout) is set, and capture waits for the next falling edge.
- R6: The count register returns the number of stored words; each read of the data register returns the oldest word and removes it; reading data while empty returns 0 and leaves count at 0.
- R7: Status bit 8 (receive) is set by a push that leaves at least level+1 words in the FIFO, level being config bits [13:8].
- R8: A push while the FIFO holds DEPTH words and no pop happens in that cycle drops the new word and sets status bit 10 (overflow); the stored words keep their order and values.
- R9: A push and a data read in the same cycle on a full FIFO are both accepted: count stays at DEPTH, the oldest word is returned, and overflow is not set.
- R10: Writing 1 to clear bit 16, 17 or 18 clears status bit 8, 9 or 10; a 0 in a clear bit leaves its status bit unchanged.
- R11: Mask bits 8, 9 and 10 disable the matching source when 1 (all set at reset); status bits 24 to 26 read the unmasked copies, and irq is high exactly when one of them is 1.
- R12: Writing 0 to enable stops capture; edges on the input then push nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt, OR of unmasked status sources |

## Verification
The FIFO push caused by a falling input edge and a software pop of the data register can land in the same clock while the FIFO is full. The bench fills the FIFO to sixteen words, then drops the input and raises the data read strobe exactly in the cycle before the third clock edge after the input change, which is the edge where the synchronized edge pushes. It judges the outcome by the returned word being the oldest one, count still reading sixteen, overflow still clear, and the later drain yielding the next sixteen words in order.

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture #(
  parameter int          DEPTH       = 16,
  parameter int          UNIT_DIV    = 10,
  parameter int          BUSY_CYCLES = 8,
  parameter logic [15:0] MAXW_RST    = 16'd16000,
  parameter logic [6:0]  PRESC_RST   = 7'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [31:0] CFG_RST = {MAXW_RST, 2'b00, 6'd0, 1'b1, PRESC_RST};
  localparam logic [5:0] A_EN = 6'h00, A_CFG = 6'h04, A_BUSY = 6'h08, A_CNT = 6'h0C,
                         A_DATA = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18, A_CLR = 6'h1C,
                         A_GO = 6'h20;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  logic          en, running;
  logic [BW-1:0] busy_cnt;
  logic [31:0]   cfg;
  logic [2:0]    mask, st, masked, st_set, st_clr;
  logic          s1, s2, sd, fall, rise;
  state_t        state;
  logic [15:0]   lo_cnt, hi_cnt, div_cnt, unit_lim, maxw, nxt_lo, nxt_hi, hi_sat;
  logic [16:0]   sum;
  logic          tick, edge_now, close_max, push_req, push_ok, drop, pop, full, rcv_set;
  logic [31:0]   push_word;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;

  wire wr_en  = reg_wr && reg_addr == A_EN;
  wire wr_go  = reg_wr && reg_addr == A_GO;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, sd} <= 3'b111;
    else        {s1, s2, sd} <= {ir_in, s1, s2};

  assign fall = sd & ~s2;
  assign rise = ~sd & s2;

  assign maxw     = cfg[31:16];
  assign unit_lim = (16'(cfg[6:0]) + 16'd1) * 16'(UNIT_DIV) - 16'd1;
  assign tick     = running && state != S_IDLE && div_cnt == unit_lim;
  assign edge_now = (state == S_LOW && rise) || (state == S_HIGH && fall);
  assign nxt_lo   = (state == S_LOW)  ? lo_cnt + 16'd1 : lo_cnt;
  assign nxt_hi   = (state == S_HIGH) ? hi_cnt + 16'd1 : hi_cnt;
  assign sum      = {1'b0, nxt_lo} + {1'b0, nxt_hi};
  assign hi_sat   = (nxt_lo >= maxw) ? 16'd0 : maxw - nxt_lo;
  assign close_max = tick && !edge_now && sum >= {1'b0, maxw};
  assign push_req  = close_max || (running && state == S_HIGH && fall);
  assign push_word = close_max ? {hi_sat, nxt_lo} : {hi_cnt, lo_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; lo_cnt <= '0; hi_cnt <= '0; div_cnt <= '0;
    end else if (!running) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (fall) begin
          state <= S_LOW; lo_cnt <= '0; hi_cnt <= '0; div_cnt <= '0;
        end
        S_LOW: if (rise) begin
          state <= S_HIGH; div_cnt <= '0;
        end else if (close_max) state <= S_IDLE;
        else if (tick) begin lo_cnt <= nxt_lo; div_cnt <= '0; end
        else div_cnt <= div_cnt + 16'd1;
        S_HIGH: if (fall) begin
          state <= S_LOW; lo_cnt <= '0; hi_cnt <= '0; div_cnt <= '0;
        end else if (close_max) state <= S_IDLE;
        else if (tick) begin hi_cnt <= nxt_hi; div_cnt <= '0; end
        else div_cnt <= div_cnt + 16'd1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign full    = cnt == CW'(DEPTH);
  assign pop     = reg_rd && reg_addr == A_DATA && cnt != '0;
  assign push_ok = push_req && (!full || pop);
  assign drop    = push_req && full && !pop;
  assign cnt_nxt = cnt + CW'(push_ok) - CW'(pop);
  assign rcv_set = push_ok && 7'(cnt_nxt) > {1'b0, cfg[13:8]};

  always_ff @(posedge clk) if (push_ok) mem[wp] <= push_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop)     rp <= rp + 1'b1;
      cnt <= cnt_nxt;
    end

  assign st_set = {drop, close_max, rcv_set};
  assign st_clr = (reg_wr && reg_addr == A_CLR) ? reg_wdata[18:16] : 3'b000;
  assign masked = st & ~mask;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; running <= 1'b0; busy_cnt <= '0; cfg <= CFG_RST; mask <= 3'b111; st <= '0;
    end else begin
      st <= (st & ~st_clr) | st_set;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (wr_en) begin
        en <= reg_wdata[0];
        if (reg_wdata[0] && !en) busy_cnt <= BW'(BUSY_CYCLES);
        if (!reg_wdata[0]) running <= 1'b0;
      end
      if (wr_go && en && busy_cnt == '0) running <= 1'b1;
      if (reg_wr && reg_addr == A_CFG)  cfg  <= reg_wdata;
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[10:8];
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd)
      case (reg_addr)
        A_EN:   reg_rdata = {31'd0, en};
        A_CFG:  reg_rdata = cfg;
        A_BUSY: reg_rdata = {31'd0, busy_cnt != '0};
        A_CNT:  reg_rdata = 32'(cnt);
        A_DATA: reg_rdata = (cnt != '0) ? mem[rp] : 32'd0;
        A_MASK: reg_rdata = {21'd0, mask, 8'd0};
        A_STAT: reg_rdata = {5'd0, masked, 13'd0, st, 8'd0};
        default: reg_rdata = '0;
      endcase
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R8
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) drop |=> cnt == CW'(DEPTH)); // R8
  AST_BUSY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n) busy_cnt != '0 |-> !running); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) mask == 3'b111 |-> !irq); // R11
  AST_PUSH_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) push_req |-> running); // R12
endmodule

// File: tb/ir_symbol_capture_bench.sv
module ir_symbol_capture_bench;
  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int n_chk = 0, n_err = 0;

  localparam logic [5:0] A_EN = 6'h00, A_CFG = 6'h04, A_BUSY = 6'h08, A_CNT = 6'h0C,
                         A_DATA = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18, A_CLR = 6'h1C,
                         A_GO = 6'h20;

  ir_symbol_capture u_ir_symbol_capture (.clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic phase(logic lvl, int clks);
    ir_in = lvl;
    repeat (clks) @(negedge clk);
  endtask

  function automatic logic [31:0] word(int lo, int hi);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CFG, d);  check("R1 config", d, 32'h3E80_0080);
    rd(A_MASK, d); check("R1 mask", d, 32'h0000_0700);
    rd(A_CNT, d);  check("R1 count", d, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_BUSY, d); check("R1 busy", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(A_EN, 1);
    rd(A_BUSY, d); check("R2 busy after enable", d, 1);
    wr(A_GO, 1);
    repeat (10) @(negedge clk);
    rd(A_BUSY, d); check("R2 busy done", d, 0);
    phase(0, 15); phase(1, 15); phase(0, 15); phase(1, 40);
    rd(A_CNT, d); check("R2 start while busy ignored", d, 0);
    wr(A_CFG, 32'h0014_0080);
    wr(A_MASK, 0);
    wr(A_GO, 1);
  endtask

  task automatic t_symbols;
    logic [31:0] d;
    phase(1, 100);
    rd(A_CNT, d); check("R4 idle high no word", d, 0);
    phase(0, 35); phase(1, 25);
    phase(0, 15); phase(1, 55);
    phase(0, 25); phase(1, 260);
    rd(A_CNT, d); check("R6 count three", d, 3);
    rd(A_STAT, d); check("R5 R7 status rcv+timeout", d, 32'h0300_0300);
    check("R11 irq high", 32'(irq), 1);
    rd(A_DATA, d); check("R3 first word", d, word(3, 2));
    rd(A_DATA, d); check("R3 second word", d, word(1, 5));
    rd(A_DATA, d); check("R5 timeout word saturated", d, word(2, 18));
    rd(A_DATA, d); check("R6 empty read", d, 0);
    rd(A_CNT, d);  check("R6 count after empty read", d, 0);
    wr(A_CLR, 32'h0001_0000);
    rd(A_STAT, d); check("R10 clear receive only", d, 32'h0200_0200);
    wr(A_CLR, 32'h0002_0000);
    rd(A_STAT, d); check("R10 clear timeout", d, 0);
    check("R11 irq low", 32'(irq), 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(A_CFG, 32'h0014_0280);
    phase(0, 15); phase(1, 15);
    phase(0, 15); phase(1, 15);
    phase(0, 10);
    rd(A_CNT, d);  check("R7 count two", d, 2);
    rd(A_STAT, d); check("R7 below level", d & 32'h100, 0);
    phase(1, 15);
    phase(0, 10);
    rd(A_STAT, d); check("R7 at level", d & 32'h100, 32'h100);
    phase(1, 260);
    rd(A_CNT, d);  check("R5 count after timeout", d, 4);
    wr(A_MASK, 32'h700);
    check("R11 irq masked", 32'(irq), 0);
    rd(A_STAT, d); check("R11 masked copies", d, 32'h0000_0300);
    wr(A_MASK, 0);
    check("R11 irq unmasked", 32'(irq), 1);
    for (int i = 0; i < 4; i++) rd(A_DATA, d);
    wr(A_CLR, 32'h0007_0000);
    rd(A_STAT, d); check("R10 clear all", d, 0);
    wr(A_CFG, 32'h0014_0080);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int k = 1; k <= 17; k++) begin
      phase(0, ((k % 3) + 1) * 10 + 5);
      phase(1, 15);
    end
    rd(A_CNT, d);  check("R9 full count", d, 16);
    rd(A_STAT, d); check("R9 no overflow when full", d & 32'h400, 0);
    ir_in = 1'b0;
    @(negedge clk); @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_DATA;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    check("R9 pop oldest during push", d, word(2, 1));
    phase(0, ((18 % 3) + 1) * 10 + 2);
    phase(1, 15);
    rd(A_CNT, d);  check("R9 count stays full", d, 16);
    rd(A_STAT, d); check("R9 overflow clear", d & 32'h400, 0);
    phase(0, ((19 % 3) + 1) * 10 + 5);
    phase(1, 300);
    rd(A_CNT, d);  check("R8 count after drop", d, 16);
    rd(A_STAT, d); check("R8 overflow set", d & 32'h0400_0400, 32'h0400_0400);
    for (int k = 2; k <= 17; k++) begin
      rd(A_DATA, d); check("R8 kept word", d, word((k % 3) + 1, 1));
    end
    wr(A_CLR, 32'h0004_0000);
    rd(A_STAT, d); check("R10 overflow cleared", d & 32'h400, 0);
    wr(A_CLR, 32'h0007_0000);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(A_EN, 0);
    phase(0, 25); phase(1, 25); phase(0, 25); phase(1, 300);
    rd(A_CNT, d);  check("R12 no capture when disabled", d, 0);
    rd(A_STAT, d); check("R12 no status when disabled", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_symbols;
    t_level;
    t_overflow;
    t_disable;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule